// File: doc/BRIEF.md
# UART Transmitter with Clear-to-Send Flow Gating

This block turns bytes into asynchronous serial frames on one output line. Software-side logic writes bytes through a one-cycle write strobe. Depending on a mode input, the bytes land either in a single-entry holding register or in a 16-entry first-in first-out buffer. The serializer drains them one frame at a time. Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period of 1, 1.5 or 2 bit times. The line rests high between frames.

Bit timing comes from an internal 16x tick. The tick divider restarts at every start bit, so each bit lasts exactly 16 ticks and each tick lasts `cfg_baud_div` system clocks. With automatic flow control switched on, an active-low clear-to-send input is synchronized and filtered. A new frame starts only once that input has been seen asserted for a fixed number of cycles. This keeps the delay from clear-to-send assertion to the start edge inside a window of one to five units of six system clocks. A frame already on the line always runs to its end.

The block reports the buffer fill level. It also has a transmitter-empty flag that covers both the buffer and the serializer, and a holding-empty interrupt that covers the buffer alone.

Top module: `uart_txaf_top`

## Requirements
- R1: After reset `txd` is 1, `fifo_level` is 0, and both `tx_empty` and `thr_empty_irq` are 1.
- R2: A frame is a 0 start bit, then N data bits sent LSB first, where N = 5 + `cfg_data_bits` (code 0 gives 5 bits, code 3 gives 8), then the optional parity bit, then the stop period at 1. Whenever no frame is in progress, `txd` is 1.
- R3: When `cfg_parity_en` is 1, a parity bit follows the data. With `cfg_parity_odd` = 1 it makes the count of ones in data plus parity odd; with 0 it makes that count even. When `cfg_parity_en` is 0, no parity bit is sent.
- R4: One bit lasts 16 ticks and one tick lasts `cfg_baud_div` clocks (0 counts as 1). The stop period lasts 16 ticks for `cfg_stop_mode` 0, 24 ticks for 1, and 32 ticks for 2 or 3. Queued frames follow each other with no gap: the interval from one start edge to the next equals the frame length exactly.
- R5: With `cfg_fifo_en` = 1 the buffer holds up to 16 bytes, sends them in write order, and `fifo_level` reports the count.
- R6: With `cfg_fifo_en` = 0 the buffer holds one byte, so `fifo_level` never exceeds 1.
- R7: A write while the buffer is full changes neither the level nor the sent data. The extra byte is never transmitted.
- R8: With `cfg_autoflow` = 1 a start bit begins only while the synchronized `cts_n` is low. With `cfg_autoflow` = 0, `cts_n` has no effect.
- R9: With `cfg_autoflow` = 1, data waiting and the line idle, the start edge follows the fall of `cts_n` after no fewer than 6 and no more than 30 clocks.
- R10: Raising `cts_n` during a frame does not cut that frame short. It blocks only the next start, which then waits for `cts_n` to fall again.
- R11: `tx_empty` is 1 only when the buffer is empty and no frame is in progress. `thr_empty_irq` is 1 whenever the buffer is empty, including while the last frame is still being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fifo_en | input | 1 | 1: 16-entry buffer, 0: single holding register |
| cfg_data_bits | input | 2 | Data length code, N = 5 + code |
| cfg_parity_en | input | 1 | Send a parity bit |
| cfg_parity_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_stop_mode | input | 2 | 0: 1 stop bit, 1: 1.5 stop bits, 2/3: 2 stop bits |
| cfg_autoflow | input | 1 | Gate start bits on clear-to-send |
| cfg_baud_div | input | 16 | System clocks per 16x tick (0 counts as 1) |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Byte to send |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| txd | output | 1 | Serial output line |
| fifo_level | output | 5 | Bytes waiting in the buffer |
| tx_empty | output | 1 | Buffer and serializer both empty |
| thr_empty_irq | output | 1 | Buffer empty interrupt |

## Verification
A read or write pointer that is off by one shows up in the first frame after it happens: the byte on the line is a repeated or skipped one. If the full limit is wrong, `fifo_level` passes 16, or passes 1 in holding mode, on the very write that overflows, and a seventeenth byte later appears on the line. A tick or stop counter that counts wrong moves the next start edge by whole ticks, so the gap between two back-to-back frames exposes it within one frame. A flow-gate counter or synchronizer that is out of step either starts a frame while clear-to-send is high or pushes the start latency outside 6 to 30 clocks. Both are visible at the first start edge after clear-to-send changes.

// File: rtl/uart_txaf_pkg.sv
package uart_txaf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  localparam int TICKS_PER_BIT = 16;

  // Number of data bits for a length code.
  function automatic logic [3:0] frame_data_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  // Stop period in 16x ticks.
  function automatic logic [5:0] stop_tick_count(input logic [1:0] mode);
    case (mode)
      2'd0:    return 6'd16;
      2'd1:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // Parity bit over the low len bits; odd=1 gives an odd total of ones.
  function automatic logic parity_of(input logic [7:0] d, input logic [3:0] len,
                                     input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++) begin
      if (i < int'(len)) p = p ^ d[i];
    end
    return p;
  endfunction

endpackage

// File: rtl/uart_txaf_buffer.sv
module uart_txaf_buffer #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fifo_en,
  input  logic                     wr_en,
  input  logic [W-1:0]             wr_data,
  input  logic                     pop,
  output logic [W-1:0]             rd_data,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty,
  output logic                     mode_chg
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] cnt, cap;
  logic          mode_q, push, take;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign cap      = fifo_en ? LW'(DEPTH) : LW'(1);
  assign mode_chg = fifo_en != mode_q;
  assign full     = cnt >= cap;
  assign empty    = cnt == '0;
  assign push     = wr_en && !full && !mode_chg;
  assign take     = pop && !empty && !mode_chg;
  assign rd_data  = mem[rp];
  assign level    = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      mode_q <= 1'b0;
    end else if (mode_chg) begin
      // A mode switch empties the buffer.
      wp     <= '0;
      rp     <= '0;
      cnt    <= '0;
      mode_q <= fifo_en;
    end else begin
      if (push) wp <= ptr_next(wp);
      if (take) rp <= ptr_next(rp);
      case ({push, take})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

endmodule

// File: rtl/uart_txaf_cts_gate.sv
module uart_txaf_cts_gate #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  output logic cts_sync_asrt,
  output logic gate_ok
);
  localparam int CW = $clog2(HOLD + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= ~cts_n;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ~cts_n};
      end
    end
  endgenerate

  assign cts_sync_asrt = sync_q[SYNC_STAGES-1];

  // Consecutive asserted cycles, saturating at HOLD.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!cts_sync_asrt)    cnt <= '0;
    else if (cnt != CW'(HOLD))  cnt <= cnt + CW'(1);
  end

  assign gate_ok = cnt == CW'(HOLD);

endmodule

// File: rtl/uart_txaf_baud.sv
module uart_txaf_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] pre, lim;

  assign lim  = (div == '0) ? '0 : div - DIV_W'(1);
  assign tick = pre == lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pre <= '0;
    else if (restart || tick) pre <= '0;
    else                      pre <= pre + DIV_W'(1);
  end

endmodule

// File: rtl/uart_txaf_serializer.sv
module uart_txaf_serializer
  import uart_txaf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       can_start,
  input  logic [7:0] rd_data,
  input  logic [1:0] cfg_data_bits,
  input  logic       cfg_parity_en,
  input  logic       cfg_parity_odd,
  input  logic [1:0] cfg_stop_mode,
  output logic       start_evt,
  output logic       bit_end,
  output logic       busy,
  output logic       txd
);
  tx_state_e  st;
  logic [7:0] sh;
  logic [2:0] bidx;
  logic [5:0] tcnt, blen;
  logic [3:0] dlen;
  logic       par_q, txd_q;
  logic       last_data;

  assign dlen      = frame_data_len(cfg_data_bits);
  assign blen      = (st == ST_STOP) ? stop_tick_count(cfg_stop_mode) : 6'(TICKS_PER_BIT);
  assign bit_end   = (st != ST_IDLE) && tick && (tcnt == blen - 6'd1);
  assign start_evt = can_start && ((st == ST_IDLE) || ((st == ST_STOP) && bit_end));
  assign last_data = bidx == 3'(dlen - 4'd1);
  assign busy      = st != ST_IDLE;
  assign txd       = txd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      sh    <= '0;
      bidx  <= '0;
      tcnt  <= '0;
      par_q <= 1'b0;
      txd_q <= 1'b1;
    end else if (start_evt) begin
      st    <= ST_START;
      sh    <= rd_data;
      par_q <= parity_of(rd_data, dlen, cfg_parity_odd);
      bidx  <= '0;
      tcnt  <= '0;
      txd_q <= 1'b0;
    end else if (bit_end) begin
      tcnt <= '0;
      case (st)
        ST_START: begin
          st    <= ST_DATA;
          txd_q <= sh[0];
        end
        ST_DATA: begin
          if (last_data) begin
            if (cfg_parity_en) begin
              st    <= ST_PAR;
              txd_q <= par_q;
            end else begin
              st    <= ST_STOP;
              txd_q <= 1'b1;
            end
          end else begin
            bidx  <= bidx + 3'd1;
            sh    <= {1'b0, sh[7:1]};
            txd_q <= sh[1];
          end
        end
        ST_PAR: begin
          st    <= ST_STOP;
          txd_q <= 1'b1;
        end
        default: begin
          st    <= ST_IDLE;
          txd_q <= 1'b1;
        end
      endcase
    end else if (tick && (st != ST_IDLE)) begin
      tcnt <= tcnt + 6'd1;
    end
  end

endmodule

// File: rtl/uart_txaf_top.sv
module uart_txaf_top #(
  parameter int FIFO_DEPTH  = 16,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CTS_HOLD    = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_fifo_en,
  input  logic [1:0]                  cfg_data_bits,
  input  logic                        cfg_parity_en,
  input  logic                        cfg_parity_odd,
  input  logic [1:0]                  cfg_stop_mode,
  input  logic                        cfg_autoflow,
  input  logic [DIV_W-1:0]            cfg_baud_div,
  input  logic                        wr_en,
  input  logic [7:0]                  wr_data,
  input  logic                        cts_n,
  output logic                        txd,
  output logic [$clog2(FIFO_DEPTH):0] fifo_level,
  output logic                        tx_empty,
  output logic                        thr_empty_irq
);
  logic [7:0] rd_data;
  logic       buf_full, buf_empty, buf_mode_chg;
  logic       cts_sync_asrt, gate_ok, can_start;
  logic       start_evt, bit_end, ser_busy, baud_tick;

  uart_txaf_buffer #(.DEPTH(FIFO_DEPTH), .W(8)) buf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_en  (cfg_fifo_en),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .pop      (start_evt),
    .rd_data  (rd_data),
    .level    (fifo_level),
    .full     (buf_full),
    .empty    (buf_empty),
    .mode_chg (buf_mode_chg)
  );

  uart_txaf_cts_gate #(.SYNC_STAGES(SYNC_STAGES), .HOLD(CTS_HOLD)) gate_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cts_n         (cts_n),
    .cts_sync_asrt (cts_sync_asrt),
    .gate_ok       (gate_ok)
  );

  assign can_start = !buf_empty && !buf_mode_chg && (!cfg_autoflow || gate_ok);

  uart_txaf_baud #(.DIV_W(DIV_W)) baud_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_evt),
    .div     (cfg_baud_div),
    .tick    (baud_tick)
  );

  uart_txaf_serializer ser_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (baud_tick),
    .can_start      (can_start),
    .rd_data        (rd_data),
    .cfg_data_bits  (cfg_data_bits),
    .cfg_parity_en  (cfg_parity_en),
    .cfg_parity_odd (cfg_parity_odd),
    .cfg_stop_mode  (cfg_stop_mode),
    .start_evt      (start_evt),
    .bit_end        (bit_end),
    .busy           (ser_busy),
    .txd            (txd)
  );

  assign tx_empty      = buf_empty && !ser_busy;
  assign thr_empty_irq = buf_empty;

endmodule

// File: rtl/uart_txaf_checker.sv
module uart_txaf_checker #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic [LW-1:0] fifo_level,
  input logic          tx_empty,
  input logic          thr_empty_irq,
  input logic          wr_en,
  input logic          cfg_fifo_en,
  input logic          cfg_autoflow,
  input logic          buf_full,
  input logic          buf_mode_chg,
  input logic          start_evt,
  input logic          bit_end,
  input logic          ser_busy,
  input logic          cts_sync_asrt
);

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_busy |-> txd);  // R2

  AST_TXD_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_evt || bit_end) |=> $stable(txd));  // R4

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && buf_full && !start_evt && !buf_mode_chg |=> $stable(fifo_level));  // R7

  AST_HOLDING_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fifo_en && !buf_mode_chg |-> fifo_level <= LW'(1));  // R6

  AST_START_NEEDS_CTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt && cfg_autoflow |-> cts_sync_asrt);  // R8

  AST_START_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !tx_empty);  // R11

  AST_WRITE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !buf_full && !buf_mode_chg |=> !thr_empty_irq);  // R11

endmodule

bind uart_txaf_top uart_txaf_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .txd           (txd),
  .fifo_level    (fifo_level),
  .tx_empty      (tx_empty),
  .thr_empty_irq (thr_empty_irq),
  .wr_en         (wr_en),
  .cfg_fifo_en   (cfg_fifo_en),
  .cfg_autoflow  (cfg_autoflow),
  .buf_full      (buf_full),
  .buf_mode_chg  (buf_mode_chg),
  .start_evt     (start_evt),
  .bit_end       (bit_end),
  .ser_busy      (ser_busy),
  .cts_sync_asrt (cts_sync_asrt)
);

// File: tb/uart_txaf_tb.sv
`timescale 1ns/1ps
module uart_txaf_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_fifo_en = 1'b1;
  logic [1:0]  cfg_data_bits = 2'd3;
  logic        cfg_parity_en = 1'b0;
  logic        cfg_parity_odd = 1'b0;
  logic [1:0]  cfg_stop_mode = 2'd0;
  logic        cfg_autoflow = 1'b0;
  logic [15:0] cfg_baud_div = 16'd1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        cts_n = 1'b0;
  logic        txd;
  logic [4:0]  fifo_level;
  logic        tx_empty, thr_empty_irq;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_txaf_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_data_bits(cfg_data_bits),
    .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .cfg_stop_mode(cfg_stop_mode), .cfg_autoflow(cfg_autoflow), .cfg_baud_div(cfg_baud_div),
    .wr_en(wr_en), .wr_data(wr_data), .cts_n(cts_n), .txd(txd), .fifo_level(fifo_level),
    .tx_empty(tx_empty), .thr_empty_irq(thr_empty_irq)
  );

  function automatic int stop_ticks(input int m);
    return (m == 0) ? 16 : ((m == 1) ? 24 : 32);
  endfunction

  function automatic int frame_clks(input int n, input int pen, input int m, input int d);
    return ((1 + n + pen) * 16 + stop_ticks(m)) * d;
  endfunction

  function automatic int par_bit(input int data, input int n, input int odd);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += (data >> i) & 1;
    return odd ? ((ones % 2 == 0) ? 1 : 0) : (ones % 2);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) step();
  endtask

  task automatic put(input logic [7:0] d);
    wr_data = d;
    wr_en   = 1'b1;
    step();
    wr_en   = 1'b0;
  endtask

  // Waits for a start edge, then decodes and checks one frame.
  task automatic recv(input int exp_d, output int t0);
    int n, pen, m, d, b, got, to;
    n   = 5 + int'(cfg_data_bits);
    pen = int'(cfg_parity_en);
    m   = int'(cfg_stop_mode);
    d   = (cfg_baud_div == 0) ? 1 : int'(cfg_baud_div);
    b   = 16 * d;
    to  = 0;
    while (txd !== 1'b0 && to < 6000) begin step(); to++; end
    t0 = cyc;
    if (to >= 6000) begin
      chk(1'b0, "R2", "start bit timeout", 1, 0);
      return;
    end
    wait_until(t0 + b / 2);
    chk(txd == 1'b0, "R2", "start bit level", int'(txd), 0);
    got = 0;
    for (int k = 0; k < n; k++) begin
      wait_until(t0 + (1 + k) * b + b / 2);
      got |= int'(txd) << k;
    end
    chk(got == (exp_d & ((1 << n) - 1)), "R2", "data bits LSB first", got, exp_d & ((1 << n) - 1));
    if (pen != 0) begin
      wait_until(t0 + (1 + n) * b + b / 2);
      chk(int'(txd) == par_bit(exp_d, n, int'(cfg_parity_odd)), "R3", "parity bit",
          int'(txd), par_bit(exp_d, n, int'(cfg_parity_odd)));
    end
    wait_until(t0 + (1 + n + pen) * b + stop_ticks(m) * d / 2);
    chk(txd == 1'b1, "R2", "stop level", int'(txd), 1);
    wait_until(t0 + frame_clks(n, pen, m, d) - 1);
    chk(txd == 1'b1, "R4", "stop held to its end", int'(txd), 1);
  endtask

  task automatic expect_quiet(input int cycles, input string req);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin
      step();
      if (txd == 1'b0) lows++;
    end
    chk(lows == 0, req, "line stays idle", lows, 0);
  endtask

  // Watchdog: counts as a failure and still reaches the summary.
  always @(posedge clk) begin
    if (cyc > 190000) begin
      n_chk++;
      n_err++;
      $display("FAIL R2 watchdog expired: actual %0d expected below 190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int t0, tp, c0, nb, fl;
    logic [7:0] bytes [4];
    void'($urandom(32'd20240611));

    repeat (5) step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(fifo_level == 5'd0, "R1", "level after reset", int'(fifo_level), 0);
    chk(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
    chk(thr_empty_irq == 1'b1, "R1", "irq after reset", int'(thr_empty_irq), 1);

    // R5 R7 R8 R9: fill FIFO while CTS is high, overflow once, then release.
    cfg_fifo_en = 1'b1; cfg_autoflow = 1'b1; cts_n = 1'b1;
    cfg_data_bits = 2'd3; cfg_parity_en = 1'b0; cfg_stop_mode = 2'd0; cfg_baud_div = 16'd1;
    repeat (4) step();
    for (int i = 0; i < 17; i++) put(8'(8'h30 + i));
    chk(fifo_level == 5'd16, "R7", "level after 17 writes", int'(fifo_level), 16);
    expect_quiet(100, "R8");
    chk(fifo_level == 5'd16, "R5", "level held while blocked", int'(fifo_level), 16);
    c0 = cyc;
    cts_n = 1'b0;
    recv(8'h30, t0);
    chk((t0 - c0) >= 6 && (t0 - c0) <= 30, "R9", "CTS-to-start latency", t0 - c0, 9);
    for (int i = 1; i < 16; i++) begin
      tp = t0;
      recv(8'h30 + i, t0);
      chk(t0 - tp == frame_clks(8, 0, 0, 1), "R4", "back-to-back interval",
          t0 - tp, frame_clks(8, 0, 0, 1));
    end
    expect_quiet(300, "R7");
    chk(tx_empty == 1'b1, "R7", "empty after 16 frames", int'(tx_empty), 1);

    // R10: CTS rises mid-frame; the frame completes, the next waits.
    cfg_data_bits = 2'd3;
    fork
      begin put(8'hA5); put(8'h5A); repeat (60) step(); cts_n = 1'b1; end
      begin recv(8'hA5, t0); end
    join
    expect_quiet(3 * frame_clks(8, 0, 0, 1), "R10");
    chk(fifo_level == 5'd1, "R10", "second byte still queued", int'(fifo_level), 1);
    chk(tx_empty == 1'b0, "R11", "not empty while byte waits", int'(tx_empty), 0);
    cts_n = 1'b0;
    recv(8'h5A, t0);

    // R6: holding mode keeps a single byte.
    cts_n = 1'b1; cfg_fifo_en = 1'b0;
    repeat (4) step();
    put(8'h3C); put(8'hC3);
    chk(fifo_level == 5'd1, "R6", "holding level after two writes", int'(fifo_level), 1);
    chk(thr_empty_irq == 1'b0, "R11", "irq low with byte held", int'(thr_empty_irq), 0);
    cts_n = 1'b0;
    recv(8'h3C, t0);
    expect_quiet(300, "R6");
    chk(tx_empty == 1'b1, "R6", "empty after single byte", int'(tx_empty), 1);

    // R8 R11: autoflow off ignores CTS; irq high while last frame shifts.
    cfg_fifo_en = 1'b1; cfg_autoflow = 1'b0; cts_n = 1'b1;
    repeat (4) step();
    fork
      begin put(8'h96); end
      begin recv(8'h96, t0); end
      begin
        repeat (30) step();
        chk(thr_empty_irq == 1'b1, "R11", "irq during last frame", int'(thr_empty_irq), 1);
        chk(tx_empty == 1'b0, "R11", "tx_empty during last frame", int'(tx_empty), 0);
      end
    join
    repeat (3) step();
    chk(tx_empty == 1'b1, "R11", "tx_empty after last frame", int'(tx_empty), 1);

    // R4: 1.5 stop bits, 5 data bits, divider 2.
    cfg_data_bits = 2'd0; cfg_stop_mode = 2'd1; cfg_baud_div = 16'd2; cts_n = 1'b0;
    fork
      begin put(8'h15); put(8'h0A); end
      begin
        recv(8'h15, tp);
        recv(8'h0A, t0);
        chk(t0 - tp == frame_clks(5, 0, 1, 2), "R4", "1.5 stop interval",
            t0 - tp, frame_clks(5, 0, 1, 2));
      end
    join
    repeat (4) step();

    // Constrained random rounds: FIFO bursts and holding-mode singles.
    for (int r = 0; r < 30; r++) begin
      cfg_fifo_en    = (r % 3) != 2;
      cfg_data_bits  = 2'($urandom_range(0, 3));
      cfg_parity_en  = 1'($urandom_range(0, 1));
      cfg_parity_odd = 1'($urandom_range(0, 1));
      cfg_stop_mode  = 2'($urandom_range(0, 3));
      cfg_baud_div   = 16'($urandom_range(0, 2));
      cfg_autoflow   = 1'($urandom_range(0, 1));
      cts_n          = 1'b0;
      nb = cfg_fifo_en ? int'($urandom_range(1, 4)) : 1;
      for (int i = 0; i < 4; i++) bytes[i] = 8'($urandom);
      repeat (4) step();
      fl = frame_clks(5 + int'(cfg_data_bits), int'(cfg_parity_en), int'(cfg_stop_mode),
                      (cfg_baud_div == 0) ? 1 : int'(cfg_baud_div));
      fork
        begin for (int i = 0; i < nb; i++) put(bytes[i]); end
        begin
          for (int i = 0; i < nb; i++) begin
            tp = t0;
            recv(int'(bytes[i]), t0);
            if (i > 0) chk(t0 - tp == fl, "R4", "random interval", t0 - tp, fl);
          end
        end
      join
      repeat (3) step();
      chk(tx_empty == 1'b1, "R5", "empty after random round", int'(tx_empty), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule